// File: doc/BRIEF.md
# Mode-Decoded Bit-Clearing Byte Memory

This block is a synthesizable, clocked model of an 8192 x 8 erasable programmable byte memory. A host presents an address, a set of active-low controls (chip select, output enable and program strobe) and a flag that says the high programming supply is present. From these the block decodes five modes: read, standby, program, program verify and program inhibit. The data port is split into an input byte, an output byte and a drive enable. The drive enable is high only in read or verify mode.

Programming works in one direction only. On the falling edge of the program strobe, while the chip is selected and the programming supply is present, the addressed byte is ANDed with the input byte. A 1 in the input byte leaves the stored bit as it was, and a 0 clears it. The only way to bring bits back to 1 is the bulk erase. It sweeps one location per clock and writes 0xFF to each one, with a busy flag high for the whole sweep.

All inputs are sampled on the rising clock edge. Read data reaches the outputs from the array in the same cycle.

Top module: `byte_prom`

## Requirements
- R1: The array holds 2^13 = 8192 bytes. `addr` selects one of them, and address 0 and address 8191 are separate, independent locations.
- R2: Erase starts at a rising clock edge where `erase` is 1 and `busy` is 0. From that edge `busy` is 1 for exactly 8192 cycles. Once `busy` falls, every location reads 0xFF.
- R3: Read mode is `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_on`=0. In this mode `data_oe` is 1 and `data_out` equals the stored byte at `addr` in the same cycle.
- R4: With `ce_n`=1, `data_oe` is 0 and `data_out` is 0x00, for any `oe_n` level.
- R5: With `ce_n`=0 and `vpp_on`=0, if either `oe_n`=1 or `pgm_n`=0, then `data_oe` is 0 and `data_out` is 0x00.
- R6: A program write happens at a rising edge where `ce_n`=0, `vpp_on`=1, `pgm_n`=0, and `pgm_n` was 1 at the previous edge. The write sets byte[addr] = byte[addr] AND `data_in`. Holding `pgm_n` low over further edges writes nothing more.
- R7: In program mode (`ce_n`=0, `vpp_on`=1, `pgm_n`=0), `data_oe` is 0 whatever the level of `oe_n`.
- R8: Program verify is `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_on`=1. In this mode the stored byte at `addr` is driven, with `data_oe`=1.
- R9: A strobe pulse with `ce_n`=1 (program inhibit) leaves the array unchanged. A strobe pulse with `vpp_on`=0 also leaves the array unchanged.
- R10: Programming never sets a bit. A location that holds a 0 bit still reads 0 in that bit after it is programmed with a 1 there.
- R11: While `busy` is 1, `data_oe` is 0, strobe pulses write nothing, and further `erase` requests have no effect on the sweep length.
- R12: After reset, `busy` is 0 and `data_oe` is 0 until a read or verify mode is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 13 | Byte address |
| data_in | input | 8 | Byte to program (AND mask) |
| data_out | output | 8 | Stored byte when driven, else 0x00 |
| data_oe | output | 1 | High when the data port is driven |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | High programming supply present |
| erase | input | 1 | Bulk erase request |
| busy | output | 1 | Erase sweep in progress |

## Verification
The checker assumes that `addr` and the controls are synchronous to `clk`. It also assumes that a strobe is not presented on the same edge as an erase request. The bench changes every input only on the falling clock edge, and it never starts a program pulse in the cycle that raises `erase`. The stability check on driven data assumes that no strobe edge can occur between two driven cycles. This follows because driving requires `pgm_n` high, and the stimulus keeps `addr` fixed whenever it expects an unchanged byte.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STANDBY  = 3'd0,
    MD_INHIBIT  = 3'd1,
    MD_READ     = 3'd2,
    MD_IDLE     = 3'd3,
    MD_PROGRAM  = 3'd4,
    MD_VERIFY   = 3'd5,
    MD_HV_IDLE  = 3'd6
  } prom_mode_e;
endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic pgm_n,
  input  logic vpp_on,
  output logic drive,
  output logic prog
);
  prom_mode_e mode;

  always_comb begin
    if (ce_n) begin
      mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_on) begin
      if (!pgm_n)     mode = MD_PROGRAM;
      else if (!oe_n) mode = MD_VERIFY;
      else            mode = MD_HV_IDLE;
    end else begin
      mode = (!oe_n && pgm_n) ? MD_READ : MD_IDLE;
    end
  end

  assign drive = (mode == MD_READ) || (mode == MD_VERIFY);
  assign prog  = (mode == MD_PROGRAM);
endmodule

// File: rtl/prom_erase_sweep.sv
module prom_erase_sweep #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/byte_prom.sv
module byte_prom
  import prom_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_on,
  input  logic              erase,
  output logic              busy
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              pgm_q;
  logic              drive, prog;
  logic              strobe_fire, sweep_start;
  logic [ADDR_W-1:0] sweep_idx;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  prom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_on (vpp_on),
    .drive  (drive),
    .prog   (prog)
  );

  // previous strobe level, for falling-edge detection
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pgm_q <= 1'b1;
    else          pgm_q <= pgm_n;
  end

  assign sweep_start = erase && rst_i_n;
  assign strobe_fire = prog && pgm_q && !busy && rst_i_n;

  prom_erase_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (sweep_start),
    .busy  (busy),
    .idx   (sweep_idx)
  );

  // single write port: sweep has the port while busy, else strobe
  always_comb begin
    wr_en   = busy || strobe_fire;
    wr_addr = busy ? sweep_idx : addr;
    wr_data = busy ? {BYTE_W{1'b1}} : (rd_data & data_in);
  end

  prom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_cells (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr),
    .rdata (rd_data)
  );

  assign data_oe  = drive && !busy && rst_i_n;
  assign data_out = data_oe ? rd_data : '0;
endmodule

// File: rtl/prom_checker.sv
module prom_checker #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_on,
  input logic              data_oe,
  input logic [7:0]        data_out,
  input logic              busy
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_standby_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !data_oe);

  p_drive_needs_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ce_n && !oe_n && pgm_n));

  p_program_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && vpp_on && !pgm_n) |-> !data_oe);

  p_busy_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_oe);

  p_sweep_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == DEPTH_V));

  p_read_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && $stable(addr)) |-> $stable(data_out));
endmodule

bind byte_prom prom_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .pgm_n    (pgm_n),
  .vpp_on   (vpp_on),
  .data_oe  (data_oe),
  .data_out (data_out),
  .busy     (busy)
);

// File: tb/sim_byte_prom.sv
`timescale 1ns/1ps
module sim_byte_prom;
  localparam int AW = 13;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    data_in, data_out;
  logic          data_oe, ce_n, oe_n, pgm_n, vpp_on, erase, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] ref_mem [N];
  bit ref_busy  = 1'b0;
  int ref_idx   = 0;
  bit ref_pprev = 1'b1;

  always #2 clk = ~clk;

  byte_prom u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_on(vpp_on), .erase(erase), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, advance the model over the edge
  task automatic cyc(input logic [AW-1:0] a, input logic [7:0] d,
                     input bit c, input bit o, input bit p, input bit v,
                     input bit e, input string req);
    bit drv, fire, start;
    addr = a; data_in = d; ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; erase = e;
    #1;
    drv = !ref_busy && !c && !o && p;
    chk({req, " drive"}, {7'd0, data_oe}, {7'd0, drv});
    chk({req, " data"}, data_out, drv ? ref_mem[a] : 8'h00);
    chk({req, " busy"}, {7'd0, busy}, {7'd0, ref_busy});
    fire  = !c && v && !p && ref_pprev && !ref_busy;
    start = e && !ref_busy;
    if (ref_busy) begin
      ref_mem[ref_idx] = 8'hFF;
      ref_idx++;
      if (ref_idx == N) ref_busy = 1'b0;
    end else begin
      if (fire) ref_mem[a] = ref_mem[a] & d;
      if (start) begin ref_busy = 1'b1; ref_idx = 0; end
    end
    ref_pprev = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(a, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic vfy(input logic [AW-1:0] a, input string req);
    cyc(a, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, req);
  endtask

  // full strobe pulse in program mode, strobe held low for two edges
  task automatic burn(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    cyc(a, d, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, req);
    cyc(a, d, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, req);
    cyc(a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, req);
    cyc(a, d, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, req);
  endtask

  task automatic sweep(input string req);
    cyc('0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, req);
    while (ref_busy) begin
      // R11: reads, strobes and new erase requests during the sweep
      if (ref_idx % 700 == 3)
        cyc(13'd5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
      else if (ref_idx % 3 == 0)
        cyc(13'd5, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
      else
        cyc(13'd5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, req);
    end
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; data_in = '0; ce_n = 1'b1; oe_n = 1'b1;
    pgm_n = 1'b1; vpp_on = 1'b0; erase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12: idle after reset
    cyc('0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R12");
    // R2: bulk erase, then all ones
    sweep("R2");
    rd(13'd0, "R2");
    rd(13'd4095, "R2");
    rd(13'd8191, "R2");
    // R3 read, R4 standby with oe low, R5 active but undriven
    rd(13'd7, "R3");
    cyc(13'd7, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    cyc(13'd7, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    cyc(13'd7, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    cyc(13'd7, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R6 program, R7 no drive while strobing, R8 verify
    burn(13'd5, 8'hA5, "R6");
    vfy(13'd5, "R8");
    rd(13'd5, "R6");
    // R10: only clears
    burn(13'd5, 8'hF0, "R10");
    rd(13'd5, "R10");
    burn(13'd5, 8'hFF, "R10");
    rd(13'd5, "R10");
    // R7: oe low during program mode
    cyc(13'd5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    cyc(13'd5, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    // R9: inhibit (ce high) and missing supply
    cyc(13'd9, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    cyc(13'd9, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    cyc(13'd9, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    cyc(13'd9, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    cyc(13'd9, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    rd(13'd9, "R9");
    // R1: both ends of the range, written out of order
    burn(13'd8191, 8'h3C, "R1");
    burn(13'd0, 8'hC3, "R1");
    rd(13'd8191, "R1");
    rd(13'd0, "R1");
    rd(13'd4096, "R1");
    vfy(13'd8191, "R1");
    // R2 again: second erase restores programmed bytes
    sweep("R2");
    rd(13'd5, "R2");
    rd(13'd0, "R2");
    rd(13'd8191, "R2");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule